// File: doc/BRIEF.md
# Sprite Blitter Pixel Engine

This engine draws one rectangular sprite into a frame buffer whose lines are 512 pixels apart. It reads packed source pixels, 1 to 8 bits wide, from a bit-addressed source memory. It writes 16-bit words to the frame buffer through a single write port. A register block decodes the drawing parameters and presents them together with a one-cycle start pulse. The engine captures them, walks the destination rows and columns, and pulses done when the last row has been handled.

Zero and nonzero source pixels each have their own action: copy, solid fill, or leave the destination alone. The destination may be mirrored in x and in y, with wraparound, and is limited by a clip rectangle. The source may carry a one-byte header per row that describes leading and trailing transparent runs. Start and end skips trim each row. Independent 8.8 fixed-point steps scale the sprite horizontally and vertically.

Top module: `sprite_blit_engine`

## Requirements
- R1: After reset the engine is idle: busy, done and dst_we are low.
- R2: Zero source pixels: with act_sel bit 2 set the write is pal_base OR fill_colour; otherwise, with act_sel bit 0 set, the write is pal_base alone.
- R3: Nonzero source pixels: with act_sel bit 3 set the write is pal_base OR fill_colour; otherwise, with act_sel bit 1 set, the write is pal_base OR the pixel value.
- R4: A pixel class whose two act_sel bits are both clear produces no write, so act_sel = 0 draws nothing.
- R5: Pixels are packed LSB first at a running bit address that starts at src_base. bpp_code 1..7 gives that many bits and 0 gives 8. The bit address moves by the pixel width for each source pixel consumed.
- R6: The destination x starts at pos_x and moves +1 per destination pixel, or −1 when flip_x is set, wrapping in 10 bits. The write address is y*512 + x.
- R7: The destination y starts at pos_y and moves +1 per destination row, or −1 when flip_y is set, wrapping in 9 bits.
- R8: Rows whose y lies outside clip_top..clip_bot get no writes, but the source still advances past them.
- R9: Pixels whose x lies outside clip_left..clip_right are not written, but they still consume source.
- R10: With row_skip_en set, each source row begins with a header byte. Its low nibble shifted left by lead_exp gives L, the count of leading unstored pixels. Its high nibble shifted left by trail_exp gives T, the count of trailing unstored pixels. Pixel indices below L are not written and consume no source, and the row holds max(size_w − L − T, 0) stored pixels.
- R11: Pixel indices below start_skip are not written. A row ends at index min(size_w − T, size_w − end_skip). Skipped pixels still move the destination x.
- R12: With scaling, an 8.8 accumulator advances by step_x per destination pixel, and the source pixel index is its integer part. A y accumulator advances by step_y per destination row, and whole source rows, each with its own header, are skipped by the change in its integer part. A step of 0 means 1.0.
- R13: done is a one-cycle pulse after the last row. A start with size_h = 0 gives done on the following cycle with no writes.
- R14: A start pulse while busy is ignored. The running draw keeps the parameters captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture parameters and begin a draw |
| act_sel | input | 4 | Pixel action bits (see R2–R4) |
| flip_x | input | 1 | Mirror horizontally |
| flip_y | input | 1 | Mirror vertically |
| row_skip_en | input | 1 | Source rows carry a header byte |
| lead_exp | input | 2 | Leading-run shift |
| trail_exp | input | 2 | Trailing-run shift |
| bpp_code | input | 3 | Pixel width, 0 means 8 |
| src_base | input | 24 | Source start bit address |
| pos_x | input | 10 | Start x |
| pos_y | input | 9 | Start y |
| size_w | input | 10 | Columns |
| size_h | input | 10 | Rows |
| pal_base | input | 16 | Palette base |
| fill_colour | input | 8 | Fill colour |
| clip_top | input | 9 | First visible row |
| clip_bot | input | 9 | Last visible row |
| clip_left | input | 10 | First visible column |
| clip_right | input | 10 | Last visible column |
| start_skip | input | 10 | Undrawn pixels at row start |
| end_skip | input | 10 | Undrawn pixels at row end |
| step_x | input | 16 | Horizontal 8.8 step |
| step_y | input | 16 | Vertical 8.8 step |
| src_addr | output | 21 | Source byte address |
| src_word | input | 16 | Bytes at src_addr+1 and src_addr |
| dst_we | output | 1 | Destination write strobe |
| dst_addr | output | 19 | Destination word address |
| dst_data | output | 16 | Destination data |
| busy | output | 1 | Draw in progress |
| done | output | 1 | Draw finished pulse |

## Verification
The main function is driven through every action combination. Zero- and nonzero-heavy pixel widths of 1, 2, 3, 4 and 8 bits show whether the two classes are decoded apart and whether fill overrides copy. Sprites placed near x and y zero, with and without mirroring, check wraparound. Clip windows that cut rows and columns show that source consumption continues while writes stop. Header bytes whose runs exceed the width, together with upscale and downscale steps in both axes, check the source bookkeeping across skipped rows. Every write is matched in order against a behavioural model.

// File: rtl/blit_pkg.sv
// Shared definitions for the sprite blitter: controller states, action bit
// positions in the act_sel field and the pixel width decode.
package blit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DRAW = 2'd2,
        ST_NEXT = 2'd3
    } blit_state_e;

    localparam int ACT_ZERO_COPY = 0;
    localparam int ACT_NZ_COPY   = 1;
    localparam int ACT_ZERO_FILL = 2;
    localparam int ACT_NZ_FILL   = 3;

    // Pixel width in bits from the 3-bit code; code 0 stands for 8.
    function automatic logic [3:0] bpp_width(input logic [2:0] code);
        return (code == 3'd0) ? 4'd8 : {1'b0, code};
    endfunction

endpackage

// File: rtl/blit_src_extract.sv
// Source field extractor. It takes the two bytes at the current byte
// address and the bit offset inside the first one, and returns both the
// full byte starting at that bit (used as a row header) and the low
// bpp bits of it (the pixel). Assumes bpp is 1..8, so one 16-bit window
// always covers the field.
module blit_src_extract (
    input  logic [15:0] src_word,
    input  logic [2:0]  bit_ofs,
    input  logic [3:0]  bpp,
    output logic [7:0]  hdr,
    output logic [7:0]  pixel
);
    logic [7:0] win;
    logic [7:0] mask;

    // Align the field to bit 0 and mask it to the pixel width.
    always_comb begin
        win   = 8'(src_word >> bit_ofs);
        mask  = 8'((9'd1 << bpp) - 9'd1);
        hdr   = win;
        pixel = win & mask;
    end
endmodule

// File: rtl/blit_px_action.sv
// Pixel action decoder. It classifies a source pixel as zero or nonzero
// and picks fill, copy or no write from the four act bits. For each
// class, fill takes precedence over copy. Purely combinational.
module blit_px_action
    import blit_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic [7:0]       pixel,
    input  logic [3:0]       act,
    input  logic [PIX_W-1:0] palette,
    input  logic [7:0]       colour,
    output logic             wr,
    output logic [PIX_W-1:0] data
);
    logic is_zero;

    // Select the write value for the pixel's class.
    always_comb begin
        is_zero = (pixel == 8'd0);
        wr      = 1'b0;
        data    = palette;
        if (is_zero) begin
            if (act[ACT_ZERO_FILL]) begin
                wr   = 1'b1;
                data = palette | PIX_W'(colour);
            end else if (act[ACT_ZERO_COPY]) begin
                wr   = 1'b1;
                data = palette;
            end
        end else begin
            if (act[ACT_NZ_FILL]) begin
                wr   = 1'b1;
                data = palette | PIX_W'(colour);
            end else if (act[ACT_NZ_COPY]) begin
                wr   = 1'b1;
                data = palette | PIX_W'(pixel);
            end
        end
    end
endmodule

// File: rtl/blit_dda.sv
// Fixed-point step unit. It adds the step, with 0 treated as 1.0, to an
// accumulator and reports how far the integer part moved. Assumes
// ACC_W > STEP_W and that the accumulator never wraps within a draw.
module blit_dda #(
    parameter int ACC_W   = 20,
    parameter int STEP_W  = 16,
    parameter int FW      = 8,
    parameter int DELTA_W = STEP_W - FW + 1
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic [STEP_W-1:0]  step,
    output logic [ACC_W-1:0]   acc_next,
    output logic [DELTA_W-1:0] delta
);
    logic [STEP_W-1:0] eff_step;

    // Advance the accumulator and take the integer-part difference.
    always_comb begin
        eff_step = (step == '0) ? STEP_W'(1 << FW) : step;
        acc_next = acc + ACC_W'(eff_step);
        delta    = DELTA_W'(acc_next[ACC_W-1:FW] - acc[ACC_W-1:FW]);
    end
endmodule

// File: rtl/sprite_blit_engine.sv
// Sprite blitter pixel engine. It captures decoded drawing parameters on
// start and walks destination rows (ST_HDR reads the row header and skips
// source rows, ST_DRAW emits at most one pixel per cycle, ST_NEXT steps y).
// It pulses done after the last row. Assumes a combinational source memory
// that returns bytes src_addr and src_addr+1 in the same cycle.
module sprite_blit_engine
    import blit_pkg::*;
#(
    parameter int XW        = 10,
    parameter int YW        = 9,
    parameter int LINE_LOG2 = 9,
    parameter int SAW       = 24,
    parameter int STEP_W    = 16,
    parameter int FW        = 8,
    parameter int PIX_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        act_sel,
    input  logic              flip_x,
    input  logic              flip_y,
    input  logic              row_skip_en,
    input  logic [1:0]        lead_exp,
    input  logic [1:0]        trail_exp,
    input  logic [2:0]        bpp_code,
    input  logic [SAW-1:0]    src_base,
    input  logic [XW-1:0]     pos_x,
    input  logic [YW-1:0]     pos_y,
    input  logic [XW-1:0]     size_w,
    input  logic [XW-1:0]     size_h,
    input  logic [PIX_W-1:0]  pal_base,
    input  logic [7:0]        fill_colour,
    input  logic [YW-1:0]     clip_top,
    input  logic [YW-1:0]     clip_bot,
    input  logic [XW-1:0]     clip_left,
    input  logic [XW-1:0]     clip_right,
    input  logic [XW-1:0]     start_skip,
    input  logic [XW-1:0]     end_skip,
    input  logic [STEP_W-1:0] step_x,
    input  logic [STEP_W-1:0] step_y,
    output logic [SAW-4:0]    src_addr,
    input  logic [15:0]       src_word,
    output logic              dst_we,
    output logic [LINE_LOG2+YW:0] dst_addr,
    output logic [PIX_W-1:0]  dst_data,
    output logic              busy,
    output logic              done
);
    localparam int ACC_W   = XW + FW + 2;
    localparam int INT_W   = ACC_W - FW;
    localparam int SW      = XW + 2;
    localparam int DELTA_W = STEP_W - FW + 1;
    localparam int DAW     = LINE_LOG2 + YW + 1;
    localparam int RUN_W   = 7;

    typedef struct packed {
        logic [3:0]        act;
        logic              flip_x;
        logic              flip_y;
        logic              row_skip;
        logic [1:0]        lead_exp;
        logic [1:0]        trail_exp;
        logic [2:0]        bpp_code;
        logic [XW-1:0]     x0;
        logic [XW-1:0]     size_w;
        logic [XW-1:0]     size_h;
        logic [PIX_W-1:0]  palette;
        logic [7:0]        colour;
        logic [YW-1:0]     clip_top;
        logic [YW-1:0]     clip_bot;
        logic [XW-1:0]     clip_left;
        logic [XW-1:0]     clip_right;
        logic [XW-1:0]     start_skip;
        logic [XW-1:0]     end_skip;
        logic [STEP_W-1:0] step_x;
        logic [STEP_W-1:0] step_y;
    } cfg_t;

    blit_state_e          state;
    cfg_t                 cfg;
    logic [SAW-1:0]       row_src, src_ptr, stride_r;
    logic [ACC_W-1:0]     ix, iy;
    logic [XW-1:0]        sx;
    logic [YW-1:0]        sy;
    logic [DELTA_W-1:0]   rows_left;
    logic [RUN_W-1:0]     lead_r;
    logic signed [SW-1:0] end_r;

    logic [3:0]           bpp_v;
    logic [SAW-1:0]       bit_sel;
    logic [7:0]           hdr, px;
    logic [RUN_W-1:0]     lead_c, trail_c;
    logic signed [SW-1:0] w_s, stored_s, lim_a, lim_b, end_c;
    logic [XW-1:0]        stored_u;
    logic [SAW-1:0]       hdr_bits, stride_c, ptr0;
    logic                 row_vis;
    logic [INT_W-1:0]     p_idx;
    logic                 row_end, in_run, in_x, act_wr, fire;
    logic [PIX_W-1:0]     act_data;
    logic [ACC_W-1:0]     ix_next, iy_next, y_limit;
    logic [DELTA_W-1:0]   dx_delta, dy_delta;
    logic [XW-1:0]        sx_step;
    logic [YW-1:0]        sy_step;

    // Source address: the header position in ST_HDR, the pixel pointer otherwise.
    assign bit_sel  = (state == ST_HDR) ? row_src : src_ptr;
    assign src_addr = bit_sel[SAW-1:3];
    assign bpp_v    = bpp_width(cfg.bpp_code);
    assign busy     = (state != ST_IDLE);

    blit_src_extract u_extract (
        .src_word (src_word),
        .bit_ofs  (bit_sel[2:0]),
        .bpp      (bpp_v),
        .hdr      (hdr),
        .pixel    (px)
    );

    blit_px_action #(.PIX_W(PIX_W)) u_action (
        .pixel   (px),
        .act     (cfg.act),
        .palette (cfg.palette),
        .colour  (cfg.colour),
        .wr      (act_wr),
        .data    (act_data)
    );

    blit_dda #(.ACC_W(ACC_W), .STEP_W(STEP_W), .FW(FW), .DELTA_W(DELTA_W)) u_dda_x (
        .acc      (ix),
        .step     (cfg.step_x),
        .acc_next (ix_next),
        .delta    (dx_delta)
    );

    blit_dda #(.ACC_W(ACC_W), .STEP_W(STEP_W), .FW(FW), .DELTA_W(DELTA_W)) u_dda_y (
        .acc      (iy),
        .step     (cfg.step_y),
        .acc_next (iy_next),
        .delta    (dy_delta)
    );

    // Row header decode: transparent runs, stored length, row end and stride.
    always_comb begin
        lead_c   = cfg.row_skip ? (RUN_W'(hdr[3:0]) << cfg.lead_exp) : '0;
        trail_c  = cfg.row_skip ? (RUN_W'(hdr[7:4]) << cfg.trail_exp) : '0;
        w_s      = $signed(SW'(cfg.size_w));
        stored_s = w_s - $signed(SW'(lead_c)) - $signed(SW'(trail_c));
        stored_u = (stored_s < 0) ? '0 : XW'(stored_s);
        lim_a    = w_s - $signed(SW'(trail_c));
        lim_b    = w_s - $signed(SW'(cfg.end_skip));
        end_c    = (lim_b < lim_a) ? lim_b : lim_a;
        hdr_bits = cfg.row_skip ? SAW'(8) : '0;
        stride_c = hdr_bits + SAW'(stored_u) * SAW'(bpp_v);
        ptr0     = row_src + hdr_bits - SAW'(lead_c) * SAW'(bpp_v);
        row_vis  = (sy >= cfg.clip_top) && (sy <= cfg.clip_bot);
    end

    // Per-pixel qualification and coordinate steps.
    always_comb begin
        p_idx   = ix[ACC_W-1:FW];
        row_end = $signed({1'b0, p_idx}) >= $signed({end_r[SW-1], end_r});
        in_run  = (p_idx >= INT_W'(lead_r)) && (p_idx >= INT_W'(cfg.start_skip));
        in_x    = (sx >= cfg.clip_left) && (sx <= cfg.clip_right);
        fire    = (state == ST_DRAW) && !row_end && in_run && in_x && act_wr;
        sx_step = cfg.flip_x ? sx - XW'(1) : sx + XW'(1);
        sy_step = cfg.flip_y ? sy - YW'(1) : sy + YW'(1);
        y_limit = ACC_W'({cfg.size_h, {FW{1'b0}}});
    end

    // Destination write port: one registered write per qualifying pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_we   <= 1'b0;
            dst_addr <= '0;
            dst_data <= '0;
        end else begin
            dst_we <= fire;
            if (fire) begin
                dst_addr <= DAW'({sy, {LINE_LOG2{1'b0}}}) + DAW'(sx);
                dst_data <= act_data;
            end
        end
    end

    // Draw controller: capture, row header, pixel walk, row step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cfg       <= '0;
            row_src   <= '0;
            src_ptr   <= '0;
            stride_r  <= '0;
            ix        <= '0;
            iy        <= '0;
            sx        <= '0;
            sy        <= '0;
            rows_left <= '0;
            lead_r    <= '0;
            end_r     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    cfg <= '{act: act_sel, flip_x: flip_x, flip_y: flip_y,
                             row_skip: row_skip_en, lead_exp: lead_exp,
                             trail_exp: trail_exp, bpp_code: bpp_code, x0: pos_x,
                             size_w: size_w, size_h: size_h, palette: pal_base,
                             colour: fill_colour, clip_top: clip_top,
                             clip_bot: clip_bot, clip_left: clip_left,
                             clip_right: clip_right, start_skip: start_skip,
                             end_skip: end_skip, step_x: step_x, step_y: step_y};
                    row_src   <= src_base;
                    iy        <= '0;
                    sy        <= pos_y;
                    rows_left <= '0;
                    if (size_h == '0) done  <= 1'b1;
                    else              state <= ST_HDR;
                end
                ST_HDR: begin
                    if (rows_left != '0) begin
                        row_src   <= row_src + stride_c;
                        rows_left <= rows_left - DELTA_W'(1);
                    end else begin
                        lead_r   <= lead_c;
                        end_r    <= end_c;
                        stride_r <= stride_c;
                        src_ptr  <= ptr0;
                        ix       <= '0;
                        sx       <= cfg.x0;
                        state    <= row_vis ? ST_DRAW : ST_NEXT;
                    end
                end
                ST_DRAW: begin
                    if (row_end) begin
                        state <= ST_NEXT;
                    end else begin
                        sx      <= sx_step;
                        ix      <= ix_next;
                        src_ptr <= src_ptr + SAW'(dx_delta) * SAW'(bpp_v);
                    end
                end
                ST_NEXT: begin
                    iy <= iy_next;
                    sy <= sy_step;
                    if (iy_next >= y_limit) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        if (dy_delta != '0) row_src <= row_src + stride_r;
                        rows_left <= (dy_delta == '0) ? '0 : dy_delta - DELTA_W'(1);
                        state     <= ST_HDR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R13
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(cfg)); // R14
    AST_WRITE_IN_XCLIP: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> ($past(sx) >= cfg.clip_left && $past(sx) <= cfg.clip_right)); // R9
    AST_ROW_IN_YCLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAW) |-> (sy >= cfg.clip_top && sy <= cfg.clip_bot)); // R8
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAW && $past(state) == ST_DRAW) |->
        (sx == (cfg.flip_x ? $past(sx) - XW'(1) : $past(sx) + XW'(1)))); // R6
    AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && $past(state) == ST_NEXT) |->
        (sy == (cfg.flip_y ? $past(sy) - YW'(1) : $past(sy) + YW'(1)))); // R7
endmodule

// File: tb/test_sprite_blit_engine.sv
// Bench for the sprite blitter: a behavioural reference builds the ordered
// list of expected writes; every clock the observed writes are compared.
module test_sprite_blit_engine;
    localparam int MEMB = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  act_sel;
    logic        flip_x, flip_y, row_skip_en;
    logic [1:0]  lead_exp, trail_exp;
    logic [2:0]  bpp_code;
    logic [23:0] src_base;
    logic [9:0]  pos_x, size_w, size_h, clip_left, clip_right, start_skip, end_skip;
    logic [8:0]  pos_y, clip_top, clip_bot;
    logic [15:0] pal_base, step_x, step_y;
    logic [7:0]  fill_colour;
    logic [20:0] src_addr;
    logic [15:0] src_word;
    logic        dst_we, busy, done;
    logic [18:0] dst_addr;
    logic [15:0] dst_data;

    logic [7:0]  mem [MEMB];
    logic [34:0] exp_q [$];
    logic [34:0] mon_e, bad_got, bad_exp;
    int tests = 0, fails = 0, mism = 0, extra_w = 0, done_cnt = 0, cyc = 0;

    always #2.5 clk = ~clk;

    assign src_word = {mem[(int'(src_addr) + 1) % MEMB], mem[int'(src_addr) % MEMB]};

    sprite_blit_engine i_sprite_blit_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .act_sel(act_sel),
        .flip_x(flip_x), .flip_y(flip_y), .row_skip_en(row_skip_en),
        .lead_exp(lead_exp), .trail_exp(trail_exp), .bpp_code(bpp_code),
        .src_base(src_base), .pos_x(pos_x), .pos_y(pos_y), .size_w(size_w),
        .size_h(size_h), .pal_base(pal_base), .fill_colour(fill_colour),
        .clip_top(clip_top), .clip_bot(clip_bot), .clip_left(clip_left),
        .clip_right(clip_right), .start_skip(start_skip), .end_skip(end_skip),
        .step_x(step_x), .step_y(step_y), .src_addr(src_addr),
        .src_word(src_word), .dst_we(dst_we), .dst_addr(dst_addr),
        .dst_data(dst_data), .busy(busy), .done(done)
    );

    task automatic check(input string tag, input bit ok, input string detail);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: cycles %0d, expected below 190000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Per-clock monitor: every observed write must be the next expected one.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dst_we) begin
                if (exp_q.size() == 0) extra_w++;
                else begin
                    mon_e = exp_q.pop_front();
                    if (mon_e != {dst_addr, dst_data}) begin
                        if (mism == 0) begin
                            bad_got = {dst_addr, dst_data};
                            bad_exp = mon_e;
                        end
                        mism++;
                    end
                end
            end
            if (done) done_cnt++;
        end
    end

    function automatic int getbits(input int addr, input int n);
        int b, w;
        b = addr >> 3;
        w = int'(mem[b % MEMB]) | (int'(mem[(b + 1) % MEMB]) << 8);
        return (w >> (addr & 7)) & ((1 << n) - 1);
    endfunction

    task automatic row_info(input int rs, input int bv, output int lead, output int trail,
                            output int stride);
        int h, st, hb;
        lead = 0; trail = 0;
        hb = row_skip_en ? 8 : 0;
        if (row_skip_en) begin
            h = getbits(rs, 8);
            lead  = (h & 15) << lead_exp;
            trail = ((h >> 4) & 15) << trail_exp;
        end
        st = int'(size_w) - lead - trail;
        if (st < 0) st = 0;
        stride = hb + st * bv;
    endtask

    // Behavioural reference derived from R2..R12.
    task automatic model();
        int bv, rs, iy, sy, xs, ys, lim, lead, trail, stride, hb, e, ix, sx, p, pix, iy2, dy;
        int w, d, tmp1, tmp2, tmp3;
        bit we;
        exp_q.delete();
        bv  = (bpp_code == 0) ? 8 : int'(bpp_code);
        xs  = (step_x == 0) ? 256 : int'(step_x);
        ys  = (step_y == 0) ? 256 : int'(step_y);
        rs  = int'(src_base);
        iy  = 0;
        sy  = int'(pos_y);
        w   = int'(size_w);
        lim = int'(size_h) * 256;
        hb  = row_skip_en ? 8 : 0;
        while (iy < lim) begin
            row_info(rs, bv, lead, trail, stride);
            e = w - trail;
            if (w - int'(end_skip) < e) e = w - int'(end_skip);
            if (sy >= int'(clip_top) && sy <= int'(clip_bot)) begin
                ix = 0;
                sx = int'(pos_x);
                while (ix / 256 < e) begin
                    p = ix / 256;
                    if (p >= lead && p >= int'(start_skip) &&
                        sx >= int'(clip_left) && sx <= int'(clip_right)) begin
                        pix = getbits(rs + hb + (p - lead) * bv, bv);
                        we = 1'b0;
                        d = 0;
                        if (pix == 0) begin
                            if (act_sel[2])      begin we = 1'b1; d = int'(pal_base) | int'(fill_colour); end
                            else if (act_sel[0]) begin we = 1'b1; d = int'(pal_base); end
                        end else begin
                            if (act_sel[3])      begin we = 1'b1; d = int'(pal_base) | int'(fill_colour); end
                            else if (act_sel[1]) begin we = 1'b1; d = int'(pal_base) | pix; end
                        end
                        if (we) exp_q.push_back({19'(sy * 512 + sx), 16'(d)});
                    end
                    sx = flip_x ? (sx + 1023) % 1024 : (sx + 1) % 1024;
                    ix += xs;
                end
            end
            iy2 = iy + ys;
            dy  = iy2 / 256 - iy / 256;
            iy  = iy2;
            sy  = flip_y ? (sy + 511) % 512 : (sy + 1) % 512;
            if (iy < lim) begin
                for (int k = 0; k < dy; k++) begin
                    row_info(rs, bv, tmp1, tmp2, tmp3);
                    rs += tmp3;
                end
            end
        end
    endtask

    task automatic defaults();
        act_sel = 4'b0010; flip_x = 0; flip_y = 0; row_skip_en = 0;
        lead_exp = 0; trail_exp = 0; bpp_code = 0; src_base = 24'd512;
        pos_x = 10; pos_y = 20; size_w = 6; size_h = 2;
        pal_base = 16'h1200; fill_colour = 8'h5A;
        clip_top = 0; clip_bot = 511; clip_left = 0; clip_right = 1023;
        start_skip = 0; end_skip = 0; step_x = 16'h0100; step_y = 16'h0100;
    endtask

    // One draw: build the expectation, start, wait for done, compare.
    task automatic run_blit(input string tag, input bit poke);
        int n;
        model();
        n = exp_q.size();
        mism = 0; extra_w = 0; done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            pos_x = pos_x + 10'd40;
            act_sel = 4'b1111;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int t = 0; t < 20000 && done_cnt == 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(tag, mism == 0 && extra_w == 0 && exp_q.size() == 0 && done_cnt == 1,
              $sformatf("writes exp %0d: mismatches %0d (got %h exp %h) extra %0d missing %0d done %0d; expected 0,0,0,1",
                        n, mism, bad_got, bad_exp, extra_w, exp_q.size(), done_cnt));
    endtask

    initial begin
        for (int i = 0; i < MEMB; i++)
            mem[i] = (i % 7 == 0) ? 8'h00 : 8'((i * 29 + 3) ^ (i >> 3));
        defaults();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", busy == 0 && done == 0 && dst_we == 0,
              $sformatf("busy %0b done %0b we %0b, expected 0 0 0", busy, done, dst_we));

        defaults(); size_w = 9; run_blit("R3 bpp8 nonzero copy", 0);
        defaults(); bpp_code = 3; src_base = 24'd517; act_sel = 4'b0011; size_w = 11;
        run_blit("R5 bpp3 odd bit address, R2 zero copy", 0);
        defaults(); bpp_code = 1; act_sel = 4'b0101; size_w = 16;
        run_blit("R2 zero fill overrides copy, bpp1", 0);
        defaults(); bpp_code = 2; act_sel = 4'b1010; size_w = 9; size_h = 3;
        run_blit("R3 nonzero fill overrides copy, bpp2", 0);
        defaults(); act_sel = 4'b0000; run_blit("R4 no action writes nothing", 0);
        defaults(); flip_x = 1; pos_x = 2; bpp_code = 4; size_w = 7; act_sel = 4'b0011;
        run_blit("R6 flip x wraps below 0", 0);
        defaults(); pos_x = 1020; size_w = 6; act_sel = 4'b0011; run_blit("R6 x wraps past 1023", 0);
        defaults(); flip_y = 1; pos_y = 1; size_h = 4; act_sel = 4'b0011;
        run_blit("R7 flip y wraps below 0", 0);
        defaults(); clip_top = 21; clip_bot = 22; size_h = 5; act_sel = 4'b0011;
        run_blit("R8 y clip keeps source advancing", 0);
        defaults(); clip_left = 12; clip_right = 14; size_h = 3; act_sel = 4'b0011;
        run_blit("R9 x clip", 0);
        defaults(); row_skip_en = 1; lead_exp = 1; size_w = 20; size_h = 3;
        bpp_code = 4; act_sel = 4'b0011; mem[64] = 8'h21;
        run_blit("R10 row header runs", 0);
        defaults(); row_skip_en = 1; trail_exp = 2; size_w = 12; size_h = 3;
        act_sel = 4'b0111; mem[64] = 8'hF3;
        run_blit("R10 header runs wider than row", 0);
        defaults(); start_skip = 2; end_skip = 1; size_w = 8; act_sel = 4'b0011;
        run_blit("R11 start and end skip", 0);
        defaults(); step_x = 16'h0180; step_y = 16'h00C0; size_w = 8; size_h = 3;
        act_sel = 4'b0011; bpp_code = 4;
        run_blit("R12 shrink x, stretch y", 0);
        defaults(); step_x = 16'h0080; step_y = 16'h0200; row_skip_en = 1;
        size_w = 10; size_h = 5; act_sel = 4'b0011; mem[64] = 8'h12;
        run_blit("R12 stretch x, skip rows with headers", 0);
        defaults(); step_x = 0; step_y = 0; act_sel = 4'b0011;
        run_blit("R12 zero step means unity", 0);
        defaults(); size_h = 0; run_blit("R13 zero height gives done only", 0);
        defaults(); size_w = 30; size_h = 4; act_sel = 4'b0011;
        run_blit("R14 start while busy ignored", 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule